// File: doc/BRIEF.md
# Host Byte-Stream Command Decoder

This block takes host commands from a byte-wide FIFO bridge that runs at 60 MHz and delivers them, decoded, to a 100 MHz core. The bridge pulls an active-low "data available" flag low while it holds bytes. The decoder then drops its active-low output enable, and one cycle later drops its active-low read strobe. It takes one byte on every clock edge at which the strobe is low and the flag is still low. Four bytes make a command: an opcode, an address, and a 16-bit value sent high byte first.

Each complete command crosses to the core domain as a 32-bit word with a toggle handshake. In the core domain it appears as a single-cycle strobe with the opcode, address and value fields. The same strobe updates a small set of settings registers: an operating mode, a stream-select field and a 16-bit threshold. Opcodes the decoder does not recognise still produce the strobe but change no setting. The write strobe toward the host is held inactive, because returning data to the host is handled elsewhere.

Top module: `host_cmd_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `rd_n`, `oe_n` and `wr_n` are high and `cmd_vld` is low. After reset, `radar_mode` is 2'b00 (chirps triggered by the external controller), `stream_ctl` is 3'b111 and `threshold` is 0. `wr_n` stays high at all times.
- R2: `rd_n` only falls after `oe_n` was already low on the previous bridge clock edge.
- R3: `rd_n` is low only when `rxf_n` was low at the previous bridge clock edge. Exactly one byte is consumed on each bridge edge at which `rd_n` and `rxf_n` are both low.
- R4: Bytes are assembled in arrival order as opcode, address, value[15:8] and value[7:0]. They appear on `cmd_op`, `cmd_addr` and `cmd_val`.
- R5: If `rxf_n` goes high before the fourth byte of a command is taken, the bytes already gathered are discarded and no strobe is produced. The next byte the bridge offers is then treated as a new opcode.
- R6: Each complete command produces exactly one `cmd_vld` pulse, one core cycle wide. Commands are delivered in the order they arrived.
- R7: In the cycle `cmd_vld` is high, the settings already reflect that command. Opcode 0x01 loads `radar_mode` from value[1:0]. Opcode 0x03 loads `threshold` from value[15:0]. Opcode 0x04 loads `stream_ctl` from value[2:0], where a value of 1 means range-only streaming. Between strobes the settings do not change.
- R8: Any other opcode still produces the `cmd_vld` strobe, but leaves `radar_mode`, `stream_ctl` and `threshold` unchanged.
- R9: While `rxf_n` stays low across several commands, all of them are framed and delivered, with no idle gap required between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bridge clock (60 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised inside each domain |
| rxf_n | input | 1 | Bridge has data, active low |
| bdata | input | 8 | Byte from the bridge |
| oe_n | output | 1 | Bridge output enable, active low |
| rd_n | output | 1 | Bridge read strobe, active low |
| wr_n | output | 1 | Bridge write strobe, held high |
| cclk | input | 1 | Core clock (100 MHz) |
| cmd_vld | output | 1 | One-cycle strobe per command |
| cmd_op | output | 8 | Opcode of the command |
| cmd_addr | output | 8 | Address of the command |
| cmd_val | output | 16 | Value of the command |
| radar_mode | output | MODE_W | Operating mode setting |
| stream_ctl | output | STRM_W | Stream-select setting |
| threshold | output | THR_W | Threshold setting |

## Verification
The bench sends all 256 opcode values, each with a different address and value. Some commands are spaced apart by a drained bridge and some are packed back to back. A decoder that framed the bytes in the wrong order, or that lost a command packed directly behind another, would show the wrong fields or too few strobes. Truncated commands of one, two and three bytes are placed in the stream. A decoder that kept a partial command would shift every later command's fields or emit a strobe that was never sent. A bench-side model of the settings is updated on every strobe. It catches an opcode that writes the wrong register, an unknown opcode that disturbs a setting, and a wrong reset value.

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder #(
  parameter int MODE_W = 2,
  parameter int STRM_W = 3,
  parameter int THR_W = 16,
  parameter logic [STRM_W-1:0] STRM_RST = '1,
  parameter logic [7:0] OP_MODE = 8'h01,
  parameter logic [7:0] OP_THR = 8'h03,
  parameter logic [7:0] OP_STRM = 8'h04
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              rxf_n,
  input  logic [7:0]        bdata,
  output logic              oe_n,
  output logic              rd_n,
  output logic              wr_n,
  input  logic              cclk,
  output logic              cmd_vld,
  output logic [7:0]        cmd_op,
  output logic [7:0]        cmd_addr,
  output logic [15:0]       cmd_val,
  output logic [MODE_W-1:0] radar_mode,
  output logic [STRM_W-1:0] stream_ctl,
  output logic [THR_W-1:0]  threshold
);

  typedef enum logic [1:0] {S_IDLE, S_OE, S_RD} st_t;

  logic [1:0]  brst_s;
  logic        brst_n;
  st_t         st;
  logic [1:0]  cnt;
  logic [23:0] shf;
  logic [31:0] word;
  logic        req;

  always_ff @(posedge bclk or negedge rst_n)
    if (!rst_n) brst_s <= 2'b00;
    else        brst_s <= {brst_s[0], 1'b1};
  assign brst_n = brst_s[1];

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      st   <= S_IDLE;
      cnt  <= 2'd0;
      shf  <= '0;
      word <= '0;
      req  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!rxf_n) st <= S_OE;
        S_OE: begin
          cnt <= 2'd0;
          st  <= rxf_n ? S_IDLE : S_RD;
        end
        S_RD: begin
          if (rxf_n) begin
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 2'd1;
            shf <= {shf[15:0], bdata};
            if (cnt == 2'd3) begin
              word <= {shf, bdata};
              req  <= ~req;
              st   <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign oe_n = (st == S_IDLE);
  assign rd_n = (st != S_RD);
  assign wr_n = 1'b1;

  logic [1:0] crst_s;
  logic       crst_n;
  logic [2:0] rsync;
  logic       hit;

  always_ff @(posedge cclk or negedge rst_n)
    if (!rst_n) crst_s <= 2'b00;
    else        crst_s <= {crst_s[0], 1'b1};
  assign crst_n = crst_s[1];

  always_ff @(posedge cclk or negedge crst_n)
    if (!crst_n) rsync <= 3'b000;
    else         rsync <= {rsync[1:0], req};
  assign hit = rsync[2] ^ rsync[1];

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      cmd_vld    <= 1'b0;
      cmd_op     <= 8'h00;
      cmd_addr   <= 8'h00;
      cmd_val    <= 16'h0000;
      radar_mode <= '0;
      stream_ctl <= STRM_RST;
      threshold  <= '0;
    end else begin
      cmd_vld <= hit;
      if (hit) begin
        {cmd_op, cmd_addr, cmd_val} <= word;
        if (word[31:24] == OP_MODE)      radar_mode <= word[MODE_W-1:0];
        else if (word[31:24] == OP_THR)  threshold  <= word[THR_W-1:0];
        else if (word[31:24] == OP_STRM) stream_ctl <= word[STRM_W-1:0];
      end
    end
  end

endmodule

// File: rtl/host_cmd_decoder_chk.sv
module host_cmd_decoder_chk #(
  parameter int MODE_W = 2,
  parameter int STRM_W = 3,
  parameter int THR_W = 16,
  parameter logic [7:0] OP_MODE = 8'h01,
  parameter logic [7:0] OP_THR = 8'h03,
  parameter logic [7:0] OP_STRM = 8'h04
) (
  input logic              bclk,
  input logic              rst_n,
  input logic              rxf_n,
  input logic              oe_n,
  input logic              rd_n,
  input logic              cclk,
  input logic              cmd_vld,
  input logic [7:0]        cmd_op,
  input logic [15:0]       cmd_val,
  input logic [MODE_W-1:0] radar_mode,
  input logic [STRM_W-1:0] stream_ctl,
  input logic [THR_W-1:0]  threshold
);

  logic known;
  assign known = (cmd_op == OP_MODE) || (cmd_op == OP_THR) || (cmd_op == OP_STRM);

  a_r2_oe_leads_rd: assert property (@(posedge bclk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!oe_n));

  a_r3_rd_needs_rxf: assert property (@(posedge bclk) disable iff (!rst_n)
    !rd_n |-> $past(!rxf_n));

  a_r3_rd_within_oe: assert property (@(posedge bclk) disable iff (!rst_n)
    !rd_n |-> !oe_n);

  a_r6_single_pulse: assert property (@(posedge cclk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld);

  a_r7_hold_between: assert property (@(posedge cclk) disable iff (!rst_n)
    !cmd_vld |-> ($stable(radar_mode) && $stable(stream_ctl) && $stable(threshold)));

  a_r7_mode_loaded: assert property (@(posedge cclk) disable iff (!rst_n)
    (cmd_vld && cmd_op == OP_MODE) |-> radar_mode == cmd_val[MODE_W-1:0]);

  a_r8_unknown_holds: assert property (@(posedge cclk) disable iff (!rst_n)
    (cmd_vld && !known) |-> ($stable(radar_mode) && $stable(stream_ctl) && $stable(threshold)));

endmodule

bind host_cmd_decoder host_cmd_decoder_chk #(
  .MODE_W(MODE_W), .STRM_W(STRM_W), .THR_W(THR_W),
  .OP_MODE(OP_MODE), .OP_THR(OP_THR), .OP_STRM(OP_STRM)
) u_chk (
  .bclk(bclk), .rst_n(rst_n), .rxf_n(rxf_n), .oe_n(oe_n), .rd_n(rd_n),
  .cclk(cclk), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_val(cmd_val),
  .radar_mode(radar_mode), .stream_ctl(stream_ctl), .threshold(threshold)
);

// File: tb/test_host_cmd_decoder.sv
`timescale 1ns/1ps
module test_host_cmd_decoder;

  logic bclk = 1'b0, cclk = 1'b0, rst_n = 1'b0;
  logic rxf_n, oe_n, rd_n, wr_n, cmd_vld;
  logic [7:0] bdata, cmd_op, cmd_addr;
  logic [15:0] cmd_val, threshold;
  logic [1:0] radar_mode;
  logic [2:0] stream_ctl;

  always #2.0 cclk = ~cclk;
  always #3.5 bclk = ~bclk;

  host_cmd_decoder i_host_cmd_decoder (
    .bclk(bclk), .rst_n(rst_n), .rxf_n(rxf_n), .bdata(bdata),
    .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n),
    .cclk(cclk), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_val(cmd_val), .radar_mode(radar_mode), .stream_ctl(stream_ctl),
    .threshold(threshold)
  );

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [7:0]  fifo [0:2047];
  logic [31:0] expq [0:511];
  int avail = 0, ptr = 0, exp_n = 0, got_n = 0;
  bit consume;

  initial begin
    rxf_n = 1'b1;
    bdata = 8'h00;
    forever begin
      @(negedge bclk);
      consume = !rd_n && !rxf_n;
      @(posedge bclk);
      #1;
      if (consume) ptr++;
      rxf_n = !(ptr < avail);
      bdata = (ptr < avail) ? fifo[ptr] : 8'h00;
    end
  end

  task automatic push_byte(input logic [7:0] b);
    fifo[avail] = b;
    avail++;
  endtask

  task automatic push_cmd(input logic [7:0] op, input logic [7:0] ad, input logic [15:0] v);
    push_byte(op); push_byte(ad); push_byte(v[15:8]); push_byte(v[7:0]);
    expq[exp_n] = {op, ad, v};
    exp_n++;
  endtask

  task automatic drain();
    wait (ptr == avail);
    repeat (4) @(posedge bclk);
    #1;
  endtask

  task automatic settle();
    for (int k = 0; k < 200 && got_n != exp_n; k++) @(posedge cclk);
    repeat (4) @(posedge cclk);
  endtask

  logic [1:0]  m_mode = 2'b00;
  logic [2:0]  m_strm = 3'b111;
  logic [15:0] m_thr = 16'h0000;
  bit prev_vld = 0;

  initial begin
    forever begin
      @(negedge cclk);
      if (rst_n) begin
        if (cmd_vld) begin
          chk(!prev_vld, "R6 pulse width", {31'd0, prev_vld}, 32'd0);
          if (got_n >= exp_n) begin
            chk(1'b0, "R5 strobe without a full command", {cmd_op, cmd_addr, cmd_val}, 32'd0);
          end else begin
            logic [31:0] w;
            w = expq[got_n];
            chk({cmd_op, cmd_addr, cmd_val} == w, "R4 field order", {cmd_op, cmd_addr, cmd_val}, w);
            if (w[31:24] == 8'h01) m_mode = w[1:0];
            else if (w[31:24] == 8'h03) m_thr = w[15:0];
            else if (w[31:24] == 8'h04) m_strm = w[2:0];
            if (w[31:24] == 8'h01 || w[31:24] == 8'h03 || w[31:24] == 8'h04)
              chk({radar_mode, stream_ctl, threshold} == {m_mode, m_strm, m_thr}, "R7 settings",
                  {11'd0, radar_mode, stream_ctl, threshold}, {11'd0, m_mode, m_strm, m_thr});
            else
              chk({radar_mode, stream_ctl, threshold} == {m_mode, m_strm, m_thr}, "R8 unknown opcode",
                  {11'd0, radar_mode, stream_ctl, threshold}, {11'd0, m_mode, m_strm, m_thr});
            got_n++;
          end
        end
        prev_vld = cmd_vld;
      end
    end
  end

  int r2_bad = 0, wr_bad = 0;
  bit prev_rd = 1, prev_oe = 1;
  initial begin
    forever begin
      @(negedge bclk);
      if (!wr_n) wr_bad++;
      if (prev_rd && !rd_n && prev_oe) r2_bad++;
      prev_rd = rd_n;
      prev_oe = oe_n;
    end
  end

  initial begin
    repeat (5) @(posedge cclk);
    #1;
    chk({rd_n, oe_n, wr_n, cmd_vld} == 4'b1110, "R1 pins in reset", {28'd0, rd_n, oe_n, wr_n, cmd_vld}, 32'hE);
    rst_n = 1'b1;
    repeat (10) @(posedge cclk);
    #1;
    chk({rd_n, oe_n, wr_n, cmd_vld} == 4'b1110, "R1 pins after reset", {28'd0, rd_n, oe_n, wr_n, cmd_vld}, 32'hE);
    chk(radar_mode == 2'b00, "R1 mode reset", {30'd0, radar_mode}, 32'd0);
    chk(stream_ctl == 3'b111, "R1 stream reset", {29'd0, stream_ctl}, 32'd7);
    chk(threshold == 16'h0, "R1 threshold reset", {16'd0, threshold}, 32'd0);

    push_cmd(8'h04, 8'h00, 16'h0001);
    drain(); settle();
    chk(stream_ctl == 3'd1, "R7 range-only", {29'd0, stream_ctl}, 32'd1);

    for (int n = 0; n < 8; n++)
      push_cmd(8'h01 + 8'(n % 4), 8'(n), 16'h1111 * 16'(n + 1));
    drain(); settle();
    chk(got_n == exp_n, "R9 packed burst", got_n, exp_n);

    for (int o = 0; o < 256; o++) begin
      if (o % 16 == 15) begin
        drain();
        for (int k = 0; k < (o / 16) % 3 + 1; k++) push_byte(8'h04);
        drain();
        repeat (3) @(posedge bclk);
      end
      push_cmd(8'(o), ~8'(o), 16'(o * 1021 + 965));
      if (o % 4 == 3) drain();
    end
    drain(); settle();

    chk(got_n == exp_n, "R5 strobe count", got_n, exp_n);
    chk(ptr == avail, "R3 bytes consumed", ptr, avail);
    chk(r2_bad == 0, "R2 read before enable", r2_bad, 0);
    chk(wr_bad == 0, "R1 write strobe", wr_bad, 0);
    chk({rd_n, oe_n} == 2'b11, "R3 idle after drain", {30'd0, rd_n, oe_n}, 32'd3);
    chk({radar_mode, stream_ctl, threshold} == {m_mode, m_strm, m_thr}, "R7 final settings",
        {11'd0, radar_mode, stream_ctl, threshold}, {11'd0, m_mode, m_strm, m_thr});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", got_n, exp_n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule